// File: doc/BRIEF.md
# LCD Clock Divider with Reload

This block turns a system clock into the slow strobes that pace an LCD controller. A count source is chosen between the system clock itself (one count per cycle) and an external timer tick that arrives without regard to the system clock. The tick is synchronized and edge detected inside the block. The counts drive a down-counter that reloads from a host-written reload value. Every underflow toggles a divide-by-two flop, and each rising toggle emits one LCD clock strobe. The LCD clock frequency is therefore the source rate divided by (reload + 1) and then by 2.

A frame strobe is derived from the LCD clock strobes by a second counter. It fires once every n LCD strobes, where 1/n is the selected drive duty. The host writes the reload value first, then writes the control word with the source choice and the run bit. Clearing the run bit parks the whole chain in its idle state.

Top module: `lcd_clkdiv`

## Requirements
- R1: With `wr_en` high, `wr_sel`=0 stores `wr_data` as the reload value (0 to 15). `wr_sel`=1 stores the control word: `wr_data[0]` is the source (1 = system clock, 0 = alternate tick) and `wr_data[1]` is run.
- R2: With the system-clock source, the first `lcd_stb` is high in the cycle R+1 clock edges after the edge that captures the run write. Later strobes follow every 2(R+1) cycles, where R is the reload value.
- R3: Every reload value from 0 (period 2) to 15 (period 32) gives the R2 timing.
- R4: A reload write while running is used at the next underflow. The half period in progress finishes with the old value.
- R5: `lcd_stb` and `frame_stb` are single-cycle pulses.
- R6: While run is 0, neither strobe is produced, and the counter, divide-by-two flop and frame counter sit at their start values. A later run write restarts with the R2 timing.
- R7: With the alternate source, one count is taken per rising edge of `alt_tick`. With alternate rising edges every P cycles, strobes are 2(R+1)P cycles apart. If `alt_tick` is idle, no strobes appear. In system-clock mode, `alt_tick` has no effect.
- R8: `duty_sel` encoding: 0 gives n=2, 1 gives n=3, 2 and 3 give n=4. `frame_stb` is high in the cycle after every n-th `lcd_stb` counted since run was set.
- R9: After reset, both outputs are 0 and run is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_tick | input | 1 | Alternate count source, asynchronous level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = reload value, 1 = control word |
| wr_data | input | CNT_W | Write data |
| duty_sel | input | 2 | Duty selection (n = 2, 3, 4) |
| lcd_stb | output | 1 | LCD clock strobe, one cycle |
| frame_stb | output | 1 | Frame strobe, one cycle |

## Verification
The first LCD strobe is due R+1 edges after the edge that captures the run write. The bench timestamps that edge and the negative edge at which each strobe is seen, and compares the difference exactly. Each frame strobe is due one edge after the n-th LCD strobe, so the bench predicts its cycle from the LCD timing and n. For the alternate source, the synchronizer latency is constant and unknown, so only the steady spacing between strobes is compared. All outputs are sampled on the falling edge.

// File: rtl/lcd_clkdiv_pkg.sv
`timescale 1ns/1ps
package lcd_clkdiv_pkg;
   localparam int MAX_DUTY = 4;

   typedef enum logic [1:0] {
      DUTY_2   = 2'd0,
      DUTY_3   = 2'd1,
      DUTY_4   = 2'd2,
      DUTY_4B  = 2'd3
   } duty_e;

   typedef struct packed {
      logic run;
      logic src_sys;
   } ctrl_t;

   function automatic int duty_len(input logic [1:0] sel);
      case (duty_e'(sel))
         DUTY_2:  return 2;
         DUTY_3:  return 3;
         default: return 4;
      endcase
   endfunction
endpackage

// File: rtl/lcd_tick_src.sv
`timescale 1ns/1ps
module lcd_tick_src #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alt_tick,
   input  logic src_sys,
   input  logic run,
   output logic tick_en
);
   logic alt_s;
   logic alt_prev;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], alt_tick};
         end
         assign alt_s = chain_q[SYNC_STAGES-1];
      end else begin : g_direct
         assign alt_s = alt_tick;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) alt_prev <= 1'b0;
      else        alt_prev <= alt_s;
   end

   assign tick_en = run & (src_sys | (alt_s & ~alt_prev));
endmodule

// File: rtl/lcd_reload_timer.sv
`timescale 1ns/1ps
module lcd_reload_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick_en,
   input  logic [CNT_W-1:0] reload,
   output logic             lcd_stb
);
   logic [CNT_W-1:0] cnt_q;
   logic             half_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         half_q  <= 1'b0;
         lcd_stb <= 1'b0;
      end else if (!run) begin
         cnt_q   <= reload;
         half_q  <= 1'b0;
         lcd_stb <= 1'b0;
      end else begin
         lcd_stb <= 1'b0;
         if (tick_en) begin
            if (cnt_q == '0) begin
               cnt_q   <= reload;
               half_q  <= ~half_q;
               lcd_stb <= ~half_q;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lcd_frame_div.sv
`timescale 1ns/1ps
module lcd_frame_div
   import lcd_clkdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       lcd_stb,
   input  logic [1:0] duty_sel,
   output logic       frame_stb
);
   localparam int FRM_W = $clog2(MAX_DUTY);

   logic [FRM_W-1:0] fcnt_q;
   logic [FRM_W-1:0] last_idx;

   assign last_idx = FRM_W'(duty_len(duty_sel) - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         fcnt_q    <= '0;
         frame_stb <= 1'b0;
      end else begin
         frame_stb <= 1'b0;
         if (lcd_stb) begin
            if (fcnt_q >= last_idx) begin
               fcnt_q    <= '0;
               frame_stb <= 1'b1;
            end else begin
               fcnt_q <= fcnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/lcd_clkdiv.sv
`timescale 1ns/1ps
module lcd_clkdiv
   import lcd_clkdiv_pkg::*;
#(
   parameter int CNT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alt_tick,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       duty_sel,
   output logic             lcd_stb,
   output logic             frame_stb
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("lcd_clkdiv: CNT_W must be at least 2");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("lcd_clkdiv: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] reload_q;
   ctrl_t            ctrl_q;
   logic             run_q;
   logic             tick_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         ctrl_q   <= '0;
      end else if (wr_en) begin
         if (wr_sel) ctrl_q   <= '{run: wr_data[1], src_sys: wr_data[0]};
         else        reload_q <= wr_data;
      end
   end

   assign run_q = ctrl_q.run;

   lcd_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick),
      .src_sys(ctrl_q.src_sys), .run(run_q), .tick_en(tick_en)
   );

   lcd_reload_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(run_q), .tick_en(tick_en),
      .reload(reload_q), .lcd_stb(lcd_stb)
   );

   lcd_frame_div u_frm (
      .clk(clk), .rst_n(rst_n), .run(run_q), .lcd_stb(lcd_stb),
      .duty_sel(duty_sel), .frame_stb(frame_stb)
   );
endmodule

// File: rtl/lcd_clkdiv_chk.sv
`timescale 1ns/1ps
module lcd_clkdiv_chk (
   input logic clk,
   input logic rst_n,
   input logic run,
   input logic lcd_stb,
   input logic frame_stb
);
   a_r5_lcd_single: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_stb |=> !lcd_stb);

   a_r5_frame_single: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> !frame_stb);

   a_r8_frame_after_lcd: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |-> $past(lcd_stb));

   a_r6_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!lcd_stb && !frame_stb));
endmodule

bind lcd_clkdiv lcd_clkdiv_chk u_chk (
   .clk(clk), .rst_n(rst_n), .run(run_q),
   .lcd_stb(lcd_stb), .frame_stb(frame_stb)
);

// File: tb/lcd_clkdiv_tb_top.sv
`timescale 1ns/1ps
module lcd_clkdiv_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       alt_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [3:0] wr_data = '0;
   logic [1:0] duty_sel = '0;
   wire        lcd_stb;
   wire        frame_stb;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   int stb_seen = 0;
   int frm_seen = 0;
   bit alt_on = 1'b0;
   int alt_ph = 0;
   localparam int ALT_HALF = 3;

   lcd_clkdiv dut_i (
      .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .duty_sel(duty_sel),
      .lcd_stb(lcd_stb), .frame_stb(frame_stb)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (lcd_stb)   stb_seen++;
      if (frame_stb) frm_seen++;
      if (alt_on) begin
         alt_ph++;
         if (alt_ph >= ALT_HALF) begin
            alt_ph = 0;
            alt_tick = ~alt_tick;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [3:0] d, output int w);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      w = cyc;
   endtask

   task automatic wait_ev(input bit frm, output int t);
      t = -1;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (frm ? frame_stb : lcd_stb) begin
            t = cyc;
            return;
         end
      end
   endtask

   function automatic int n_of(input int d);
      return (d == 0) ? 2 : (d == 1) ? 3 : 4;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int w, t1, t2, t3, tf, tf2, s0, f0, per, n;
      repeat (4) @(negedge clk);
      check("R9 lcd_stb in reset", int'(lcd_stb), 0);
      check("R9 frame_stb in reset", int'(frame_stb), 0);
      rst_n = 1'b1;
      s0 = stb_seen;
      repeat (30) @(negedge clk);
      check("R9 idle after reset", stb_seen - s0, 0);

      // R2 R3 R6 R8 sweep, alternate tick toggling (R7: ignored in sys mode)
      alt_on = 1'b1;
      for (int r = 0; r < 16; r++) begin
         for (int d = 0; d < 4; d++) begin
            n = n_of(d);
            per = 2 * (r + 1);
            wr(1'b1, 4'b0001, w);
            wr(1'b0, 4'(r), w);
            duty_sel = 2'(d);
            wr(1'b1, 4'b0011, w);
            wait_ev(1'b0, t1);
            check($sformatf("R2 R6 first strobe r=%0d", r), t1 - w, r + 1);
            wait_ev(1'b0, t2);
            check($sformatf("R3 R7 period r=%0d", r), t2 - t1, per);
            wait_ev(1'b1, tf);
            check($sformatf("R8 first frame r=%0d n=%0d", r, n), tf - w,
                  r + 1 + per * (n - 1) + 1);
            wait_ev(1'b1, tf2);
            check($sformatf("R8 frame period r=%0d n=%0d", r, n), tf2 - tf, per * n);
         end
      end
      alt_on = 1'b0;

      // R4: reload change mid run
      duty_sel = 2'd0;
      wr(1'b1, 4'b0001, w);
      wr(1'b0, 4'd5, w);
      wr(1'b1, 4'b0011, w);
      wait_ev(1'b0, t1);
      wr(1'b0, 4'd2, w);
      wait_ev(1'b0, t2);
      check("R4 transition period", t2 - t1, 6 + 3);
      wait_ev(1'b0, t3);
      check("R4 new period", t3 - t2, 6);

      // R6: stopped produces nothing
      wr(1'b1, 4'b0001, w);
      s0 = stb_seen; f0 = frm_seen;
      repeat (80) @(negedge clk);
      check("R6 no lcd strobe stopped", stb_seen - s0, 0);
      check("R6 no frame strobe stopped", frm_seen - f0, 0);

      // R7: alternate source
      wr(1'b0, 4'd2, w);
      wr(1'b1, 4'b0000, w);
      alt_on = 1'b1;
      wr(1'b1, 4'b0010, w);
      wait_ev(1'b0, t1);
      wait_ev(1'b0, t2);
      wait_ev(1'b0, t3);
      check("R7 alt period a", t2 - t1, 2 * 3 * 2 * ALT_HALF);
      check("R7 alt period b", t3 - t2, 2 * 3 * 2 * ALT_HALF);
      alt_on = 1'b0;
      wr(1'b1, 4'b0000, w);
      wr(1'b1, 4'b0010, w);
      s0 = stb_seen;
      repeat (150) @(negedge clk);
      check("R7 alt idle no strobe", stb_seen - s0, 0);

      // R1: control bit 0 picks source; run again in sys mode
      wr(1'b1, 4'b0011, w);
      wait_ev(1'b0, t1);
      check("R1 control write sys source", t1 - w, 3);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule